// File: doc/BRIEF.md
# Guest TLB Invalidate-All Sequencer

This block holds a small, fully associative translation cache and carries out an invalidate-all command aimed at the guest (level-1/level-0) translation regime on the local core only. Accepting the command clears every guest-regime entry in one cycle. Entries are not told apart by virtual machine identifier, address-space identifier or global bit: all of them are packed into the tag, and the invalidate ignores the tag. Entries that the hypervisor's own regime owns stay valid.

Completion is the harder part. The block follows memory accesses in flight through an issue port and a retire port. Each access carries a slot number, an XS attribute bit and a regime bit. When a command is accepted, the in-scope accesses in flight at that moment are copied into a pending mask. The done pulse is held back until the mask drains. The normal variant waits on every guest-regime access in the copy. The exclude-XS variant waits only on those whose XS bit is clear. A build-time parameter sets whether the exclude-XS variant also spares cached entries that have XS set. A second command is held off by the ready/valid handshake until the first completes.

Top module: `guest_tlb_flush`

## Requirements
- R1: After reset, cmdReady is 1, flushDone is 0 and every lookup misses.
- R2: An accepted normal command (cmdNoXs=0) invalidates every entry filled with fillHyp=0, whatever its tag and XS bit.
- R3: Entries filled with fillHyp=1 stay valid across either command variant.
- R4: With KEEP_XS_ENTRIES=1, an accepted exclude-XS command (cmdNoXs=1) invalidates guest entries with fillXs=0 and leaves guest entries with fillXs=1 valid.
- R5: After a normal command, flushDone stays 0 until every guest access (issHyp=0) in flight in the accept cycle has retired, whatever its XS bit.
- R6: After an exclude-XS command, flushDone waits only on in-flight guest accesses with issXs=0. Accesses with XS set do not delay it.
- R7: Accesses issued in or after the accept cycle, and accesses with issHyp=1, never delay flushDone.
- R8: flushDone is a one-cycle pulse. It rises in the cycle after the last relevant retire is registered, or in the cycle after accept if nothing is pending.
- R9: cmdReady is 0 from the cycle after accept through the done cycle. A command held valid in that window is accepted only afterwards.
- R10: A lookup presented in the accept cycle misses on any entry that this command invalidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Invalidate-all command request |
| cmdNoXs | input | 1 | 1 selects the exclude-XS variant |
| cmdReady | output | 1 | Command can be accepted |
| flushDone | output | 1 | One-cycle completion pulse |
| fillValid | input | 1 | Write an entry |
| fillIdx | input | IDX_W | Entry index to write |
| fillTag | input | TAG_W | Tag (address, VMID, ASID packed) |
| fillHyp | input | 1 | Entry belongs to hypervisor regime |
| fillXs | input | 1 | Entry XS attribute |
| lookupTag | input | TAG_W | Lookup tag |
| lookupHyp | input | 1 | Lookup regime |
| lookupHit | output | 1 | Lookup hit |
| issValid | input | 1 | Access issued |
| issSlot | input | SLOT_W | Tracker slot of issued access |
| issXs | input | 1 | XS attribute of issued access |
| issHyp | input | 1 | Issued access uses hypervisor regime |
| retValid | input | 1 | Access retired |
| retSlot | input | SLOT_W | Tracker slot of retired access |

## Verification
On every cycle the assertions check the following: an accepted command drops cmdReady; a done pulse returns the block to ready; hypervisor entries survive a flush; a normal flush leaves no guest entry; and the pending mask can only shrink between accepts. Which accesses count as in scope can only be shown by the bench's scenarios. These cover XS-set accesses under each variant, late issues and hypervisor accesses. The scenarios also show the same-cycle lookup miss and the exact cycle of the done pulse.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  typedef struct packed {
    logic go;
    logic noXs;
  } invStrobe_t;

  typedef enum logic {ST_IDLE, ST_DRAIN} seqState_t;
endpackage

// File: rtl/tlbinv_datapath.sv
module tlbinv_datapath
  import tlbinv_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int SLOTS = 8,
  parameter int TAG_W = 16,
  parameter bit KEEP_XS_ENTRIES = 1'b1,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  invStrobe_t        strb,
  input  logic              fillValid,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic              fillHyp,
  input  logic              fillXs,
  input  logic [TAG_W-1:0]  lookupTag,
  input  logic              lookupHyp,
  output logic              lookupHit,
  input  logic              issValid,
  input  logic [SLOT_W-1:0] issSlot,
  input  logic              issXs,
  input  logic              issHyp,
  input  logic              retValid,
  input  logic [SLOT_W-1:0] retSlot,
  output logic              pendEmpty
);
  logic [ENTRIES-1:0] validQ, hypQ, xsQ, clearMask, matchVec;
  logic [TAG_W-1:0]   tagQ [ENTRIES];
  logic [SLOTS-1:0]   busyQ, aXsQ, aHypQ, pendQ, retMask, scopeMask;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign clearMask[i] = strb.go && !hypQ[i] &&
                          !(strb.noXs && KEEP_XS_ENTRIES && xsQ[i]);
    assign matchVec[i]  = validQ[i] && !clearMask[i] &&
                          (tagQ[i] == lookupTag) && (hypQ[i] == lookupHyp);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        hypQ[i]   <= 1'b0;
        xsQ[i]    <= 1'b0;
        tagQ[i]   <= '0;
      end else if (fillValid && fillIdx == IDX_W'(i)) begin
        validQ[i] <= 1'b1;
        hypQ[i]   <= fillHyp;
        xsQ[i]    <= fillXs;
        tagQ[i]   <= fillTag;
      end else if (clearMask[i]) begin
        validQ[i] <= 1'b0;
      end
    end
  end

  assign lookupHit = |matchVec;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign retMask[s]   = retValid && retSlot == SLOT_W'(s);
    assign scopeMask[s] = busyQ[s] && !aHypQ[s] && !(strb.noXs && aXsQ[s]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyQ[s] <= 1'b0;
        aXsQ[s]  <= 1'b0;
        aHypQ[s] <= 1'b0;
      end else if (issValid && issSlot == SLOT_W'(s)) begin
        busyQ[s] <= 1'b1;
        aXsQ[s]  <= issXs;
        aHypQ[s] <= issHyp;
      end else if (retMask[s]) begin
        busyQ[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        pendQ <= '0;
    else if (strb.go) pendQ <= scopeMask & ~retMask;
    else              pendQ <= pendQ & ~retMask;
  end

  assign pendEmpty = (pendQ == '0);

  // R3
  hyp_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.go && !fillValid |=> (validQ & hypQ) == $past(validQ & hypQ));

  // R2
  guest_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.go && !strb.noXs && !fillValid |=> (validQ & ~hypQ) == '0);

  // R7
  pend_shrink_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.go |=> (pendQ & ~$past(pendQ)) == '0);
endmodule

// File: rtl/tlbinv_ctrl.sv
module tlbinv_ctrl
  import tlbinv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdNoXs,
  input  logic       pendEmpty,
  output logic       cmdReady,
  output logic       flushDone,
  output invStrobe_t strb
);
  seqState_t stateQ;

  assign cmdReady  = (stateQ == ST_IDLE);
  assign strb.go   = cmdValid && cmdReady;
  assign strb.noXs = cmdNoXs;
  assign flushDone = (stateQ == ST_DRAIN) && pendEmpty;

  always_ff @(posedge clk) begin
    if (!rstN)          stateQ <= ST_IDLE;
    else if (strb.go)   stateQ <= ST_DRAIN;
    else if (flushDone) stateQ <= ST_IDLE;
  end

  // R9
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> !cmdReady);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> cmdReady && !flushDone);
endmodule

// File: rtl/guest_tlb_flush.sv
module guest_tlb_flush
  import tlbinv_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int SLOTS = 8,
  parameter int TAG_W = 16,
  parameter bit KEEP_XS_ENTRIES = 1'b1,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdNoXs,
  output logic              cmdReady,
  output logic              flushDone,
  input  logic              fillValid,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic              fillHyp,
  input  logic              fillXs,
  input  logic [TAG_W-1:0]  lookupTag,
  input  logic              lookupHyp,
  output logic              lookupHit,
  input  logic              issValid,
  input  logic [SLOT_W-1:0] issSlot,
  input  logic              issXs,
  input  logic              issHyp,
  input  logic              retValid,
  input  logic [SLOT_W-1:0] retSlot
);
  invStrobe_t strb;
  logic       pendEmpty;

  tlbinv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdNoXs(cmdNoXs),
    .pendEmpty(pendEmpty), .cmdReady(cmdReady), .flushDone(flushDone),
    .strb(strb)
  );

  tlbinv_datapath #(
    .ENTRIES(ENTRIES), .SLOTS(SLOTS), .TAG_W(TAG_W),
    .KEEP_XS_ENTRIES(KEEP_XS_ENTRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .fillValid(fillValid), .fillIdx(fillIdx), .fillTag(fillTag),
    .fillHyp(fillHyp), .fillXs(fillXs),
    .lookupTag(lookupTag), .lookupHyp(lookupHyp), .lookupHit(lookupHit),
    .issValid(issValid), .issSlot(issSlot), .issXs(issXs), .issHyp(issHyp),
    .retValid(retValid), .retSlot(retSlot), .pendEmpty(pendEmpty)
  );
endmodule

// File: tb/guest_tlb_flush_bench.sv
module guest_tlb_flush_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, cmdNoXs = 0, cmdReady, flushDone;
  logic fillValid = 0, fillHyp = 0, fillXs = 0;
  logic [2:0] fillIdx = '0;
  logic [15:0] fillTag = '0, lookupTag = '0;
  logic lookupHyp = 0, lookupHit;
  logic issValid = 0, issXs = 0, issHyp = 0, retValid = 0;
  logic [2:0] issSlot = '0, retSlot = '0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guest_tlb_flush u_guest_tlb_flush (.*);

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic fill(input int idx, input int tag, input logic hyp, input logic xs);
    fillValid = 1; fillIdx = 3'(idx); fillTag = 16'(tag); fillHyp = hyp; fillXs = xs;
    step(); fillValid = 0;
  endtask

  task automatic issue(input int slot, input logic xs, input logic hyp);
    issValid = 1; issSlot = 3'(slot); issXs = xs; issHyp = hyp;
    step(); issValid = 0;
  endtask

  task automatic retire(input int slot);
    retValid = 1; retSlot = 3'(slot);
    step(); retValid = 0;
  endtask

  task automatic look(input int tag, input logic hyp, input logic exp, input string req);
    lookupTag = 16'(tag); lookupHyp = hyp; #1;
    chk(lookupHit, exp, req);
  endtask

  // returns in the cycle after accept
  task automatic send(input logic noXs);
    cmdValid = 1; cmdNoXs = noXs;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    step(); cmdValid = 0;
  endtask

  task automatic loadSet();
    fill(0, 5, 0, 0); fill(1, 6, 0, 1); fill(2, 7, 1, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmdReady, 1, "R1 ready");
    chk(flushDone, 0, "R1 done");
    look(5, 0, 0, "R1 lookup");
  endtask

  task automatic t_normal();
    loadSet();
    look(6, 0, 1, "R2 prefill hit");
    cmdValid = 1; cmdNoXs = 0; lookupTag = 5; lookupHyp = 0;
    @(negedge clk);
    chk(lookupHit, 0, "R10 same-cycle miss");
    step(); cmdValid = 0;
    @(negedge clk);
    chk(flushDone, 1, "R8 done after accept");
    look(5, 0, 0, "R2 xs0 cleared");
    look(6, 0, 0, "R2 xs1 cleared");
    look(7, 1, 1, "R3 hyp kept");
    step();
    chk(flushDone, 0, "R8 pulse width");
  endtask

  task automatic t_noxs();
    loadSet();
    send(1);
    @(negedge clk);
    chk(flushDone, 1, "R6 done no pending");
    look(5, 0, 0, "R4 xs0 cleared");
    look(6, 0, 1, "R4 xs1 kept");
    look(7, 1, 1, "R3 hyp kept noXs");
    step();
    send(0); step();
  endtask

  task automatic t_drainAll();
    issue(0, 1, 0); issue(1, 0, 0);
    send(0);
    @(negedge clk);
    chk(flushDone, 0, "R5 waits");
    chk(cmdReady, 0, "R9 busy");
    retire(1);
    @(negedge clk);
    chk(flushDone, 0, "R5 xs1 still pending");
    retire(0);
    @(negedge clk);
    chk(flushDone, 1, "R5 drained");
    step();
    chk(flushDone, 0, "R8 one cycle");
    chk(cmdReady, 1, "R9 ready again");
  endtask

  task automatic t_drainNoXs();
    issue(0, 1, 0); issue(1, 0, 0);
    send(1);
    @(negedge clk);
    chk(flushDone, 0, "R6 waits xs0");
    retire(1);
    @(negedge clk);
    chk(flushDone, 1, "R6 ignores xs1");
    step();
    retire(0);
  endtask

  task automatic t_late();
    issue(2, 0, 1);
    cmdValid = 1; cmdNoXs = 0; issValid = 1; issSlot = 3; issXs = 0; issHyp = 0;
    step(); cmdValid = 0; issValid = 0;
    @(negedge clk);
    chk(flushDone, 1, "R7 late and hyp ignored");
    step();
    retire(2); retire(3);
  endtask

  task automatic t_queue();
    int pulses = 0;
    issue(4, 0, 0);
    send(0);
    cmdValid = 1; cmdNoXs = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(cmdReady, 0, "R9 second held");
    end
    retValid = 1; retSlot = 4; step(); retValid = 0;
    @(negedge clk);
    chk(flushDone, 1, "R9 first done");
    chk(cmdReady, 0, "R9 not ready in done cycle");
    step();
    chk(cmdReady, 1, "R9 second accepted");
    step(); cmdValid = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (flushDone) pulses++;
      step();
    end
    chk(pulses == 1, 1, "R9 second completes once");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rstN = 1; step();
    t_reset();
    t_normal();
    t_noxs();
    t_drainAll();
    t_drainNoXs();
    t_late();
    t_queue();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule